// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This block predicts the next fetch address of a five-stage pipelined core and works out the recovery when a prediction proves wrong. The fetch stage presents its current PC every cycle and receives, in the same cycle, a predicted-taken flag and a predicted next PC. Predictions come from a direct-mapped target buffer, whose entries hold a tag, a destination and a valid bit, and from a table of 2-bit saturating direction counters. Both are indexed by PC bits [7:2] and have 64 entries by default.

The execute stage reports each resolved control-flow instruction. It gives the instruction's PC, whether it is a conditional branch or an unconditional jump, the real outcome and computed target, and the prediction that fetch made for it. In that same cycle the block raises a redirect, with a corrected PC and a flush of fetch and decode, if the prediction was wrong. At the next clock edge it also writes the learned information into its tables.

Top module: `bp_unit`

## Requirements
- R1: After reset every target-buffer entry is invalid, so `fe_pred_taken` stays 0 and `fe_pred_pc` equals `fe_pc`+4 until the first update is written.
- R2: A lookup is a hit only when the entry at index `fe_pc[7:2]` is valid and its stored tag equals `fe_pc[31:8]`. On a miss `fe_pred_taken` is 0 and `fe_pred_pc` is `fe_pc`+4.
- R3: On a hit to an entry written by a conditional branch, the prediction is taken exactly when the direction counter at that index is in a taken state (codes 2 and 3). When taken, `fe_pred_pc` is the stored destination.
- R4: On a hit to an entry written by an unconditional jump, the prediction is always taken with the stored destination. For a jump, `ex_taken` is ignored and the outcome counts as taken.
- R5: Counters use codes 0 strong not-taken, 1 weak not-taken, 2 weak taken and 3 strong taken. They reset to 1, move one step toward the real outcome on each conditional update, and stay put at 0 and 3.
- R6: A resolved conditional branch writes the buffer entry (valid, tag, `ex_target`, conditional kind) and updates its counter. A resolved jump writes only the buffer entry (jump kind) and leaves the counter unchanged.
- R7: If the instruction was predicted not taken (`ex_pred_taken`=0) but is taken, `ex_redirect` is 1 and `ex_redirect_pc` is `ex_target`.
- R8: If the instruction was predicted taken but is not taken, `ex_redirect` is 1 and `ex_redirect_pc` is `ex_pc`+4.
- R9: If the instruction was predicted taken and is taken, but `ex_pred_pc` differs from `ex_target`, `ex_redirect` is 1 and `ex_redirect_pc` is `ex_target`.
- R10: A correct prediction gives no redirect. When `ex_valid` is 0, or when neither `ex_is_cond` nor `ex_is_jump` is set, there is no redirect and no table changes. If both kind bits are set, the instruction is treated as a jump.
- R11: When a lookup and an update fall on the same index in the same cycle, the lookup returns the contents from before the update. The update is visible from the next cycle on.
- R12: `ex_redirect` and `ex_redirect_pc` respond combinationally, in the same cycle as the execute inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fe_pc | input | ADDR_W | PC being fetched |
| fe_pred_taken | output | 1 | Prediction for `fe_pc` is taken |
| fe_pred_pc | output | ADDR_W | Predicted next fetch PC |
| ex_valid | input | 1 | A control-flow instruction resolves this cycle |
| ex_is_cond | input | 1 | Resolved instruction is a conditional branch |
| ex_is_jump | input | 1 | Resolved instruction is an unconditional jump |
| ex_pc | input | ADDR_W | PC of the resolved instruction |
| ex_taken | input | 1 | Real outcome of a conditional branch |
| ex_target | input | ADDR_W | Computed destination |
| ex_pred_taken | input | 1 | Direction that fetch predicted for it |
| ex_pred_pc | input | ADDR_W | Next PC that fetch predicted for it |
| ex_redirect | output | 1 | Misprediction: load the corrected PC, flush fetch and decode |
| ex_redirect_pc | output | ADDR_W | Corrected PC |

## Verification
The assertions check on every cycle the properties that the ports alone settle. There is no taken prediction before the first update, a not-taken prediction always falls through to PC+4, the two wrong-direction cases redirect to the right address, an idle execute stage never redirects, and a jump learned in one cycle is predicted taken in the next. Counter stepping and saturation, the jump-leaves-counter-alone rule, tag mismatches and the same-cycle collision depend on the history of updates. Only the bench's directed sequences can show them, with its reference model compared against the outputs on every clock.

// File: rtl/bp_pkg.sv
// Package bp_pkg
// Shared types for the branch predictor: direction counter states and
// the saturating step function. Assumes 2-bit counters.
package bp_pkg;

    typedef enum logic [1:0] {
        CNT_STRONG_NT = 2'd0,
        CNT_WEAK_NT   = 2'd1,
        CNT_WEAK_T    = 2'd2,
        CNT_STRONG_T  = 2'd3
    } dir_ctr_e;

    // Move one state toward the observed outcome, holding at the ends.
    function automatic dir_ctr_e ctr_step(dir_ctr_e cur, logic taken);
        dir_ctr_e nxt;
        case (cur)
            CNT_STRONG_NT: nxt = taken ? CNT_WEAK_NT  : CNT_STRONG_NT;
            CNT_WEAK_NT:   nxt = taken ? CNT_WEAK_T   : CNT_STRONG_NT;
            CNT_WEAK_T:    nxt = taken ? CNT_STRONG_T : CNT_WEAK_NT;
            default:       nxt = taken ? CNT_STRONG_T : CNT_WEAK_T;
        endcase
        return nxt;
    endfunction

    // Counter states whose upper bit is set predict taken.
    function automatic logic ctr_says_taken(dir_ctr_e cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bp_target_buf.sv
// Module bp_target_buf
// Direct-mapped branch target buffer. Each entry holds a valid bit, an
// address tag, a destination and a kind bit (jump or conditional).
// Read is combinational from the index/tag, so a same-cycle write is not
// seen until the next cycle. Only valid bits are reset.
module bp_target_buf #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = ADDR_W - IDX_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic              rd_is_jump,
    output logic [ADDR_W-1:0] rd_dest,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_dest,
    input  logic              wr_is_jump
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]  valid_q;
    logic [DEPTH-1:0]  jump_q;
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [ADDR_W-1:0] dest_q [DEPTH];

    // Valid bits: cleared by reset, set when an entry is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Payload storage: tag, destination and kind, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            dest_q[wr_idx] <= wr_dest;
            jump_q[wr_idx] <= wr_is_jump;
        end
    end

    // Combinational lookup and tag compare.
    always_comb begin
        rd_hit     = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_is_jump = jump_q[rd_idx];
        rd_dest    = dest_q[rd_idx];
    end

endmodule

// File: rtl/bp_history_table.sv
// Module bp_history_table
// Untagged table of 2-bit saturating direction counters. Read is
// combinational; a write steps the addressed counter toward the outcome.
// Assumes reset lasts at least one clock edge.
module bp_history_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output dir_ctr_e         rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    dir_ctr_e ctr_q [DEPTH];

    // Counter array: reset to weak not-taken, step on resolve.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctr_q[i] <= CNT_WEAK_NT;
            end
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
        end
    end

    // Combinational counter read.
    always_comb rd_ctr = ctr_q[rd_idx];

endmodule

// File: rtl/bp_redirect.sv
// Module bp_redirect
// Compares the prediction carried down the pipe with the resolved
// outcome and produces the corrected PC and the table write enables.
// Pure combinational. Assumes a jump is always taken.
module bp_redirect #(
    parameter int ADDR_W = 32
) (
    input  logic              ex_valid,
    input  logic              ex_is_cond,
    input  logic              ex_is_jump,
    input  logic [ADDR_W-1:0] ex_pc,
    input  logic              ex_taken,
    input  logic [ADDR_W-1:0] ex_target,
    input  logic              ex_pred_taken,
    input  logic [ADDR_W-1:0] ex_pred_pc,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic              btb_wr,
    output logic              bht_wr,
    output logic              outcome
);
    logic resolves;
    logic missed_taken;
    logic false_taken;
    logic wrong_dest;

    // Classify the resolution against the prediction.
    always_comb begin
        resolves     = ex_valid && (ex_is_cond || ex_is_jump);
        outcome      = ex_is_jump || ex_taken;
        missed_taken = outcome && !ex_pred_taken;
        false_taken  = !outcome && ex_pred_taken;
        wrong_dest   = outcome && ex_pred_taken && (ex_pred_pc != ex_target);
    end

    // Redirect decision and corrected address.
    always_comb begin
        redirect    = resolves && (missed_taken || false_taken || wrong_dest);
        redirect_pc = false_taken ? (ex_pc + ADDR_W'(4)) : ex_target;
    end

    // Table write enables: jumps touch only the target buffer.
    always_comb begin
        btb_wr = resolves;
        bht_wr = resolves && ex_is_cond && !ex_is_jump;
    end

endmodule

// File: rtl/bp_unit.sv
// Module bp_unit
// Branch predictor top: fetch-side lookup (target buffer plus direction
// counters) and execute-side misprediction redirect and training.
// Assumes ADDR_W > IDX_W + 2 and 4-byte aligned instructions.
module bp_unit
    import bp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fe_pc,
    output logic              fe_pred_taken,
    output logic [ADDR_W-1:0] fe_pred_pc,
    input  logic              ex_valid,
    input  logic              ex_is_cond,
    input  logic              ex_is_jump,
    input  logic [ADDR_W-1:0] ex_pc,
    input  logic              ex_taken,
    input  logic [ADDR_W-1:0] ex_target,
    input  logic              ex_pred_taken,
    input  logic [ADDR_W-1:0] ex_pred_pc,
    output logic              ex_redirect,
    output logic [ADDR_W-1:0] ex_redirect_pc
);
    localparam int TAG_W = ADDR_W - IDX_W - 2;

    logic              lk_hit;
    logic              lk_is_jump;
    logic [ADDR_W-1:0] lk_dest;
    dir_ctr_e          lk_ctr;
    logic              btb_wr;
    logic              bht_wr;
    logic              outcome;

    bp_target_buf #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W)
    ) u_btb (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (fe_pc[IDX_W+1:2]),
        .rd_tag     (fe_pc[ADDR_W-1:IDX_W+2]),
        .rd_hit     (lk_hit),
        .rd_is_jump (lk_is_jump),
        .rd_dest    (lk_dest),
        .wr_en      (btb_wr),
        .wr_idx     (ex_pc[IDX_W+1:2]),
        .wr_tag     (ex_pc[ADDR_W-1:IDX_W+2]),
        .wr_dest    (ex_target),
        .wr_is_jump (ex_is_jump)
    );

    bp_history_table #(
        .IDX_W (IDX_W)
    ) u_bht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (fe_pc[IDX_W+1:2]),
        .rd_ctr   (lk_ctr),
        .wr_en    (bht_wr),
        .wr_idx   (ex_pc[IDX_W+1:2]),
        .wr_taken (outcome)
    );

    bp_redirect #(
        .ADDR_W (ADDR_W)
    ) u_fix (
        .ex_valid      (ex_valid),
        .ex_is_cond    (ex_is_cond),
        .ex_is_jump    (ex_is_jump),
        .ex_pc         (ex_pc),
        .ex_taken      (ex_taken),
        .ex_target     (ex_target),
        .ex_pred_taken (ex_pred_taken),
        .ex_pred_pc    (ex_pred_pc),
        .redirect      (ex_redirect),
        .redirect_pc   (ex_redirect_pc),
        .btb_wr        (btb_wr),
        .bht_wr        (bht_wr),
        .outcome       (outcome)
    );

    // Fetch prediction: a counter only counts on a buffer hit.
    always_comb begin
        fe_pred_taken = lk_hit && (lk_is_jump || ctr_says_taken(lk_ctr));
        fe_pred_pc    = fe_pred_taken ? lk_dest : (fe_pc + ADDR_W'(4));
    end

endmodule

// File: rtl/bp_unit_chk.sv
// Module bp_unit_chk
// Port-level properties of bp_unit, attached by bind below.
module bp_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fe_pc,
    input logic              fe_pred_taken,
    input logic [ADDR_W-1:0] fe_pred_pc,
    input logic              ex_valid,
    input logic              ex_is_cond,
    input logic              ex_is_jump,
    input logic [ADDR_W-1:0] ex_pc,
    input logic              ex_taken,
    input logic [ADDR_W-1:0] ex_target,
    input logic              ex_pred_taken,
    input logic [ADDR_W-1:0] ex_pred_pc,
    input logic              ex_redirect,
    input logic [ADDR_W-1:0] ex_redirect_pc
);
    logic any_update_q;

    // Remember whether any table write has been requested since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) any_update_q <= 1'b0;
        else if (ex_valid && (ex_is_cond || ex_is_jump)) any_update_q <= 1'b1;
    end

    a_r1_cold_no_taken: assert property (@(posedge clk) disable iff (!rst_n)
        !any_update_q |-> !fe_pred_taken);

    a_r2_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_pred_taken |-> fe_pred_pc == fe_pc + ADDR_W'(4));

    a_r7_missed_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && (ex_is_jump || (ex_is_cond && ex_taken)) && !ex_pred_taken)
        |-> (ex_redirect && ex_redirect_pc == ex_target));

    a_r8_false_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_is_cond && !ex_is_jump && !ex_taken && ex_pred_taken)
        |-> (ex_redirect && ex_redirect_pc == ex_pc + ADDR_W'(4)));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |-> !ex_redirect);

    a_r4_jump_learned: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_is_jump) ##1 (fe_pc == $past(ex_pc))
        |-> (fe_pred_taken && fe_pred_pc == $past(ex_target)));

    // Unused here but part of the bound port list.
    logic unused_ok;
    always_comb unused_ok = ^ex_pred_pc;

endmodule

bind bp_unit bp_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fe_pc          (fe_pc),
    .fe_pred_taken  (fe_pred_taken),
    .fe_pred_pc     (fe_pred_pc),
    .ex_valid       (ex_valid),
    .ex_is_cond     (ex_is_cond),
    .ex_is_jump     (ex_is_jump),
    .ex_pc          (ex_pc),
    .ex_taken       (ex_taken),
    .ex_target      (ex_target),
    .ex_pred_taken  (ex_pred_taken),
    .ex_pred_pc     (ex_pred_pc),
    .ex_redirect    (ex_redirect),
    .ex_redirect_pc (ex_redirect_pc)
);

// File: tb/tb_bp_unit.sv
module tb_bp_unit;
    localparam int AW = 32;
    localparam int IW = 6;
    localparam int N  = 1 << IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [AW-1:0] fe_pc = '0;
    logic          fe_pred_taken;
    logic [AW-1:0] fe_pred_pc;
    logic          ex_valid = 0, ex_is_cond = 0, ex_is_jump = 0, ex_taken = 0, ex_pred_taken = 0;
    logic [AW-1:0] ex_pc = '0, ex_target = '0, ex_pred_pc = '0;
    logic          ex_redirect;
    logic [AW-1:0] ex_redirect_pc;

    bp_unit #(.ADDR_W(AW), .IDX_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .fe_pc(fe_pc),
        .fe_pred_taken(fe_pred_taken), .fe_pred_pc(fe_pred_pc),
        .ex_valid(ex_valid), .ex_is_cond(ex_is_cond), .ex_is_jump(ex_is_jump),
        .ex_pc(ex_pc), .ex_taken(ex_taken), .ex_target(ex_target),
        .ex_pred_taken(ex_pred_taken), .ex_pred_pc(ex_pred_pc),
        .ex_redirect(ex_redirect), .ex_redirect_pc(ex_redirect_pc)
    );

    // Behavioural reference state.
    bit          m_valid [N];
    int unsigned m_tag   [N];
    int unsigned m_dest  [N];
    bit          m_jump  [N];
    int          m_cnt   [N];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    function automatic int unsigned slot(int unsigned pc);
        return (pc >> 2) % N;
    endfunction

    task automatic check(string tag, string what, int unsigned act, int unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One clock: compare at negedge, then train the model at posedge.
    task automatic step(string tag);
        int unsigned i;
        bit hit, pt, res, act, redir;
        int unsigned ppc, rpc;
        @(negedge clk);
        i   = slot(fe_pc);
        hit = m_valid[i] && (m_tag[i] == (fe_pc >> (IW + 2)));
        pt  = hit && (m_jump[i] || m_cnt[i] >= 2);
        ppc = pt ? m_dest[i] : fe_pc + 4;
        res = ex_valid && (ex_is_cond || ex_is_jump);
        act = ex_is_jump || ex_taken;
        redir = 0;
        rpc = 0;
        if (res && act && !ex_pred_taken) begin redir = 1; rpc = ex_target; end
        else if (res && !act && ex_pred_taken) begin redir = 1; rpc = ex_pc + 4; end
        else if (res && act && ex_pred_taken && ex_pred_pc != ex_target) begin redir = 1; rpc = ex_target; end
        check(tag, "pred_taken", {31'b0, fe_pred_taken}, {31'b0, pt});
        check(tag, "pred_pc", fe_pred_pc, ppc);
        check(tag, "redirect", {31'b0, ex_redirect}, {31'b0, redir});
        if (redir) check(tag, "redirect_pc", ex_redirect_pc, rpc);
        @(posedge clk);
        if (rst_n && res) begin
            i = slot(ex_pc);
            m_valid[i] = 1;
            m_tag[i]   = ex_pc >> (IW + 2);
            m_dest[i]  = ex_target;
            m_jump[i]  = ex_is_jump;
            if (!ex_is_jump) begin
                if (act && m_cnt[i] < 3) m_cnt[i]++;
                if (!act && m_cnt[i] > 0) m_cnt[i]--;
            end
        end
        #1;
    endtask

    task automatic ex_set(bit v, bit c, bit j, int unsigned pc, bit tk,
                          int unsigned tgt, bit ptk, int unsigned ppc);
        ex_valid = v; ex_is_cond = c; ex_is_jump = j; ex_pc = pc; ex_taken = tk;
        ex_target = tgt; ex_pred_taken = ptk; ex_pred_pc = ppc;
    endtask

    task automatic ex_idle();
        ex_set(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    localparam int unsigned PA = 32'h104, PB = 32'h208, PC = 32'h30C;
    localparam int unsigned PP = 32'h400, PJ = 32'h300, PS = 32'h014;

    initial begin
        for (int k = 0; k < N; k++) begin
            m_valid[k] = 0; m_cnt[k] = 1; m_tag[k] = 0; m_dest[k] = 0; m_jump[k] = 0;
        end
        // R1: reset state and cold tables.
        fe_pc = 32'h1000;
        step("R1"); step("R1");
        rst_n = 1'b1;
        fe_pc = PA; step("R1");
        fe_pc = PB; step("R1");

        // R10: correct not-taken, then R3 hit with counter at strong not-taken.
        ex_set(1, 1, 0, PA, 0, 32'h900, 0, PA + 4); step("R10");
        ex_idle(); fe_pc = PA; step("R3");
        fe_pc = 32'h1104; step("R2");            // same slot, other tag

        // R7 then R3 taken hit.
        ex_set(1, 1, 0, PB, 1, 32'h800, 0, PB + 4); step("R7");
        ex_idle(); fe_pc = PB; step("R3");

        // R11 collision with R8 redirect, then new content visible.
        ex_set(1, 1, 0, PB, 0, 32'h800, 1, 32'h800); fe_pc = PB; step("R11");
        ex_idle(); step("R11");

        // R9 wrong target, then R10 correct taken.
        ex_set(1, 1, 0, PB, 1, 32'h800, 1, 32'h900); step("R9");
        ex_set(1, 1, 0, PB, 1, 32'h800, 1, 32'h800); step("R10");

        // R4 jump (ex_taken low is ignored), then hit.
        ex_set(1, 0, 1, PC, 0, 32'hC00, 0, PC + 4); step("R4");
        ex_idle(); fe_pc = PC; step("R4");

        // R6: jump at same slot leaves the counter alone.
        ex_set(1, 1, 0, PP, 1, 32'h040, 0, PP + 4); step("R6");
        ex_set(1, 0, 1, PJ, 1, 32'h080, 0, PJ + 4); step("R6");
        ex_set(1, 1, 0, PP, 0, 32'h040, 0, PP + 4); step("R6");
        ex_idle(); fe_pc = PP; step("R6");

        // R5 saturation both ways.
        for (int k = 0; k < 5; k++) begin
            ex_set(1, 1, 0, PS, 1, 32'h600, 1, 32'h600); step("R5");
        end
        ex_set(1, 1, 0, PS, 0, 32'h600, 1, 32'h600); step("R5");
        ex_idle(); fe_pc = PS; step("R5");
        for (int k = 0; k < 4; k++) begin
            ex_set(1, 1, 0, PS, 0, 32'h600, 0, PS + 4); step("R5");
        end
        ex_set(1, 1, 0, PS, 1, 32'h600, 0, PS + 4); step("R5");
        ex_idle(); fe_pc = PS; step("R5");

        // R10: invalid or kindless resolves change nothing.
        ex_set(0, 1, 0, PA, 1, 32'hA00, 0, PA + 4); fe_pc = PA; step("R10");
        ex_set(1, 0, 0, PA, 1, 32'hA00, 0, PA + 4); step("R10");
        ex_idle(); step("R10");

        // R12: mixed random traffic compared every cycle.
        void'($urandom(7));
        for (int k = 0; k < 400; k++) begin
            int unsigned p;
            p = ($urandom % 16) * 4 + (($urandom % 3) << 8);
            fe_pc = ($urandom % 16) * 4 + (($urandom % 3) << 8);
            ex_set($urandom % 4 != 0, $urandom % 2, $urandom % 4 == 0, p, $urandom % 2,
                   ($urandom % 8) * 16, $urandom % 2, ($urandom % 8) * 16);
            step("R12");
        end
        ex_idle();

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule